// File: doc/BRIEF.md
# SPI Master Transaction Engine

This block is a 32-bit SPI bus master. It is controlled through a narrow register port that has one address bit. Address 0 holds the data word. Writing it loads the shift register and starts one transfer. Address 1 holds a packed configuration word, which selects:
- transfer length (1 to 32 bits);
- clock divisor;
- clock idle level and sampling phase;
- bit order;
- chip-select pattern and active level;
- capture request;
- an end-of-transaction flag;
- three-wire half-duplex mode;
- a parking flag that floats every pad.

A transaction is one or more transfers. Chip select stays asserted across consecutive transfers until a transfer that was started with the end flag set has finished. The port reports busy while a transfer is shifting, and writes made during that time are discarded. When the capture flag was set at the time the data word was written, the received word is presented with a one-cycle strobe.

Top module: `spi_xfer_engine`

## Requirements
- R1: Configuration layout, bit 0 upward:
  - bit 0: park (all output enables low);
  - bit 1: end;
  - bit 2: capture;
  - bit 3: chip-select active level;
  - bit 4: clock idle level;
  - bit 5: phase;
  - bit 6: LSB-first;
  - bit 7: three-wire;
  - bits 12:8: length−1;
  - bits 23:16: divisor−2;
  - bits 31:24: chip-select pattern.

  After reset only park and end are 1, so a 1-bit, divisor-2 transfer results.
- R2: A data-word write (address 0) accepted while idle starts a transfer. With end set, busy stays high for exactly (n+1)·(divisor) cycles, where n = length.
- R3: Each SPI clock period lasts divisor cycles. When the divisor is odd, the half before the sampling edge is one cycle longer. With phase 0 the clock spends floor(div/2) cycles at the non-idle level per bit; with phase 1 it spends ceil(div/2).
- R4: The first bit sent is bit 31, or bit 0 when LSB-first is set, at any length. The last bit received lands in bit 0, or in bit 31 when LSB-first is set.
- R5: Received bits enter the register at the end opposite the transmit end. Bits not shifted out keep their earlier contents, moved along by n places.
- R6: The clock rests at the idle level outside transfers and makes exactly 2n edges per transfer. Phase 0 samples on the first edge of each bit and phase 1 on the second.
- R7: During a transaction, lines whose pattern bit is 1 take the active level and all other lines take the opposite level. The lines stay asserted across transfers while end is clear, and all lines return to inactive after a transfer started with end set.
- R8: No SPI clock edge falls in the same cycle as a chip-select edge.
- R9: Writes to either address while busy is high are ignored.
- R10: Park takes effect in the cycle after its write. Other fields take effect at the next transfer start. In particular, a pattern written between transfers of one transaction appears only when the next transfer starts.
- R11: A transfer started with capture set produces exactly one one-cycle read strobe carrying the final register word. A transfer started with capture clear produces none.
- R12: In three-wire mode, input bits are taken from mosi_i. If capture is also set, mosi_oe is low while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = data word, 1 = configuration word |
| wr_data | input | 32 | Write value |
| busy | output | 1 | Transfer shifting; writes are dropped |
| rd_valid | output | 1 | One-cycle strobe for captured word |
| rd_data | output | 32 | Shift register contents |
| sclk_o | output | 1 | SPI clock |
| sclk_oe | output | 1 | SPI clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| mosi_i | input | 1 | Data line input (three-wire receive) |
| miso_i | input | 1 | Serial data in (four-wire) |
| cs_o | output | 8 | Chip-select lines |
| cs_oe | output | 1 | Chip-select output enable |

## Verification
The assertions assume a single-master register port: wr_en is a one-cycle pulse whose address and data are valid alongside it. They also assume the configuration is changed only while the port would accept it, and that the clock idle level is not flipped in the middle of a multi-transfer transaction.

The stimulus keeps to these assumptions:
- it issues each write as a single-cycle pulse;
- it deliberately writes during busy only to exercise the drop rule;
- it keeps length and divisor inside their encodable ranges.

Received data comes from a loopback of mosi_o (optionally inverted), or from a constant on mosi_i in three-wire mode. Because of this the expected word can be derived from the transmitted word alone.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
// Shared widths and the packed configuration word of the SPI engine.
// Assumes a 32-bit register port; field positions are fixed by this struct.
package spi_eng_pkg;
    localparam int WORD_W = 32;
    localparam int CS_W   = 8;
    localparam int DIV_W  = 8;
    localparam int LEN_W  = 5;
    localparam int HALF_W = $clog2(2 * WORD_W + 2);

    typedef struct packed {
        logic [CS_W-1:0]  cs_sel;
        logic [DIV_W-1:0] div_m2;
        logic [2:0]       spare;
        logic [LEN_W-1:0] len_m1;
        logic             three_wire;
        logic             lsb_out;
        logic             phase;
        logic             idle_hi;
        logic             cs_hi;
        logic             capture;
        logic             last;
        logic             park;
    } cfg_t;

    localparam cfg_t CFG_RESET = cfg_t'(32'h0000_0003);
endpackage

// File: rtl/spi_eng_tick.sv
`timescale 1ns/1ps
// Half-period timer: reloads with the length of the coming half period and
// flags its last cycle. Assumes arm is raised only at a half boundary.
module spi_eng_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             arm,
    input  logic             long_half,
    input  logic [DIV_W-1:0] div_m2,
    output logic             expire
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] div_full;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] cnt_q;

    // Split the divisor into a long and a short half.
    always_comb begin
        div_full = {1'b0, div_m2} + CNT_W'(2);
        half_len = long_half ? ((div_full + CNT_W'(1)) >> 1) : (div_full >> 1);
        expire   = run && (cnt_q == '0);
    end

    // Count down the current half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (arm)
            cnt_q <= half_len - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/spi_eng_shift.sv
`timescale 1ns/1ps
// Transmit/receive shift register. Transmit from one end, receive into the
// other; the sampled bit is held until the following shift edge.
module spi_eng_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              sample,
    input  logic              shift,
    input  logic              din,
    input  logic              lsb_first,
    output logic              sdo,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sr_q;
    logic              rx_q;

    // Serial output bit depends on bit order.
    assign sdo  = lsb_first ? sr_q[0] : sr_q[WORD_W-1];
    assign word = sr_q;

    // Hold the bit seen on the sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_q <= 1'b0;
        else if (sample)
            rx_q <= din;
    end

    // Load on transfer start, move one place on each shift edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= load_word;
        else if (shift)
            sr_q <= lsb_first ? {rx_q, sr_q[WORD_W-1:1]} : {sr_q[WORD_W-2:0], rx_q};
    end
endmodule

// File: rtl/spi_eng_seq.sv
`timescale 1ns/1ps
// Transfer sequencer. Half 0 is chip-select setup, halves 1..2n carry the
// bits (odd halves at the non-idle clock level), half 2n+1 is chip-select
// hold and is used only when the transfer closes the transaction.
module spi_eng_seq #(
    parameter int LEN_W  = 5,
    parameter int HALF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             expire,
    input  logic             phase,
    input  logic             last,
    input  logic [LEN_W-1:0] len_m1,
    output logic             busy,
    output logic             in_txn,
    output logic             sck_act,
    output logic             sample,
    output logic             shift,
    output logic             arm,
    output logic             long_next,
    output logic             done
);
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} st_e;

    st_e               st_q;
    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] two_n;
    logic [HALF_W-1:0] nxt;
    logic              at_edge_end;
    logic              at_tail;

    // Decode the current half into clock level and shift/sample events.
    always_comb begin
        two_n       = (HALF_W'(len_m1) + HALF_W'(1)) << 1;
        nxt         = half_q + HALF_W'(1);
        at_edge_end = (half_q == two_n);
        at_tail     = (half_q == two_n + HALF_W'(1));
        busy        = (st_q == ST_RUN);
        in_txn      = (st_q != ST_IDLE);
        sck_act     = busy && half_q[0] && (half_q < two_n);
        sample      = busy && expire && (half_q < two_n) && (half_q[0] == phase);
        shift       = busy && expire && (half_q != '0) && (half_q <= two_n)
                      && (half_q[0] != phase);
        done        = busy && expire && (at_tail || (at_edge_end && !last));
        arm         = start || (busy && expire && !done);
        long_next   = start ? !phase : (nxt[0] == phase);
    end

    // Advance state and half index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            half_q <= '0;
        end else if (start) begin
            st_q   <= ST_RUN;
            half_q <= '0;
        end else if (busy && expire) begin
            if (done)
                st_q <= at_tail ? ST_IDLE : ST_HOLD;
            else
                half_q <= nxt;
        end
    end
endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
// SPI master with a one-bit-address register port. Configuration written
// while idle or between transfers is copied into the active set when a data
// word starts a transfer; only the park flag acts on the pads immediately.
module spi_xfer_engine
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic [CS_W-1:0]   cs_o,
    output logic              cs_oe
);
    cfg_t             cfg_q;
    cfg_t             act_q;
    logic             accept;
    logic             data_go;
    logic [LEN_W-1:0] sel_len;
    logic [DIV_W-1:0] sel_div;
    logic             sel_phase;
    logic             sel_lsb;
    logic             sel_last;
    logic             in_txn;
    logic             sck_act;
    logic             sample;
    logic             shift;
    logic             arm;
    logic             long_next;
    logic             done;
    logic             expire;
    logic             din;
    logic             cs_lvl;
    logic             unused_cfg;

    // Accept writes only when no transfer is shifting.
    always_comb begin
        accept    = wr_en && !busy;
        data_go   = accept && !wr_addr;
        sel_len   = data_go ? cfg_q.len_m1 : act_q.len_m1;
        sel_div   = data_go ? cfg_q.div_m2 : act_q.div_m2;
        sel_phase = data_go ? cfg_q.phase  : act_q.phase;
        sel_lsb   = data_go ? cfg_q.lsb_out : act_q.lsb_out;
        sel_last  = data_go ? cfg_q.last   : act_q.last;
    end

    // Live configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (accept && wr_addr)
            cfg_q <= cfg_t'(wr_data);
    end

    // Active configuration, captured at each transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= CFG_RESET;
        else if (data_go)
            act_q <= cfg_q;
    end

    spi_eng_seq #(.LEN_W(LEN_W), .HALF_W(HALF_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(data_go), .expire(expire),
        .phase(sel_phase), .last(sel_last), .len_m1(sel_len),
        .busy(busy), .in_txn(in_txn), .sck_act(sck_act), .sample(sample),
        .shift(shift), .arm(arm), .long_next(long_next), .done(done)
    );

    spi_eng_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .arm(arm),
        .long_half(long_next), .div_m2(sel_div), .expire(expire)
    );

    spi_eng_shift #(.WORD_W(WORD_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(data_go), .load_word(wr_data),
        .sample(sample), .shift(shift), .din(din), .lsb_first(sel_lsb),
        .sdo(mosi_o), .word(rd_data)
    );

    // Pad levels: idle polarities follow the live word outside transactions.
    always_comb begin
        din     = act_q.three_wire ? mosi_i : miso_i;
        cs_lvl  = in_txn ? act_q.cs_hi : cfg_q.cs_hi;
        sclk_o  = (in_txn ? act_q.idle_hi : cfg_q.idle_hi) ^ sck_act;
        cs_o    = in_txn ? ((act_q.cs_sel & {CS_W{cs_lvl}}) | (~act_q.cs_sel & {CS_W{~cs_lvl}}))
                         : {CS_W{~cs_lvl}};
        sclk_oe = !cfg_q.park;
        cs_oe   = !cfg_q.park;
        mosi_oe = !cfg_q.park && !(busy && act_q.three_wire && act_q.capture);
        unused_cfg = ^{act_q.park, act_q.spare, cfg_q.spare};
    end

    // One-cycle strobe for a captured word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= done && act_q.capture;
    end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
`timescale 1ns/1ps
// Port-level property checker for the SPI engine, bound to the top module.
module spi_xfer_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_addr,
    input logic       park_bit,
    input logic       busy,
    input logic       rd_valid,
    input logic       sclk_o,
    input logic       sclk_oe,
    input logic       mosi_oe,
    input logic [7:0] cs_o,
    input logic       cs_oe
);
    p_start_by_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_en) && !$past(wr_addr)));

    p_cs_sclk_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cs_o) && (busy || $past(busy))) |-> $stable(sclk_o));

    p_busy_write_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(cs_oe) && $stable(sclk_oe)));

    p_park_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_addr && park_bit) |=> (!cs_oe && !sclk_oe && !mosi_oe));

    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_strobe_after_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .park_bit(wr_data[0]), .busy(busy), .rd_valid(rd_valid),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe),
    .cs_o(cs_o), .cs_oe(cs_oe)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        busy, rd_valid, sclk_o, sclk_oe, mosi_o, mosi_oe, cs_oe;
    logic [31:0] rd_data;
    logic [7:0]  cs_o;
    logic        inv_rx = 1'b0;
    logic        hd_level = 1'b0;
    logic        mosi_i, miso_i;

    int checks = 0, errors = 0, strobes = 0, cycles = 0;
    logic [31:0] exp_q[$];
    logic [31:0] want;
    int m_busy, m_edges, m_act;
    logic [7:0] m_cs;
    logic m_mosi_oe;

    assign miso_i = mosi_o ^ inv_rx;
    assign mosi_i = hd_level;

    always #10 clk = ~clk;

    spi_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .mosi_i(mosi_i), .miso_i(miso_i), .cs_o(cs_o), .cs_oe(cs_oe)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(bit park, bit last, bit capt, bit cs_hi,
            bit idle_hi, bit phase, bit lsb, bit tw, int nbits, int divisor, logic [7:0] cs);
        logic [7:0] dv = 8'(divisor - 2);
        logic [4:0] ln = 5'(nbits - 1);
        return {cs, dv, 3'b000, ln, tw, lsb, phase, idle_hi, cs_hi, capt, last, park};
    endfunction

    // mode 0: loopback, 1: inverted loopback, 2: constant ones
    function automatic logic [31:0] model_rx(logic [31:0] d, int n, bit lsb, int mode);
        logic [31:0] r;
        logic b;
        for (int i = 0; i < 32; i++) begin
            if (!lsb) begin
                if (i < n) begin
                    b = d[32 - n + i];
                    r[i] = (mode == 2) ? 1'b1 : ((mode == 1) ? ~b : b);
                end else r[i] = d[i - n];
            end else begin
                if (i >= 32 - n) begin
                    b = d[i - 32 + n];
                    r[i] = (mode == 2) ? 1'b1 : ((mode == 1) ? ~b : b);
                end else r[i] = d[i + n];
            end
        end
        return r;
    endfunction

    task automatic reg_write(input bit addr, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input bit idle_hi);
        logic prev = idle_hi;
        int guard = 0;
        m_busy = 0; m_edges = 0; m_act = 0; m_cs = cs_o; m_mosi_oe = mosi_oe;
        while (busy && guard < 5000) begin
            m_busy++;
            if (sclk_o != prev) m_edges++;
            prev = sclk_o;
            if (sclk_o != idle_hi) m_act++;
            @(negedge clk);
            guard++;
        end
    endtask

    // Driver: push expected word, write data, measure the transfer.
    task automatic go(input logic [31:0] d, input bit capt, input logic [31:0] exp, input bit idle_hi);
        if (capt) exp_q.push_back(exp);
        reg_write(1'b0, d);
        measure(idle_hi);
    endtask

    // Monitor: compare read strobes against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            strobes++;
            if (exp_q.size() == 0)
                check(1'b0, "R11", "unexpected read strobe", rd_data, 32'h0);
            else begin
                want = exp_q.pop_front();
                check(rd_data == want, "R4/R5", "captured word", rd_data, want);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check({cs_oe, sclk_oe, mosi_oe} == 3'b000, "R1", "parked after reset", {cs_oe, sclk_oe, mosi_oe}, 0);
        check(cs_o == 8'hFF, "R1", "cs idle after reset", cs_o, 8'hFF);
        check(sclk_o == 1'b0, "R1", "clock idle after reset", sclk_o, 0);
        check(rd_valid == 1'b0, "R11", "no strobe after reset", rd_valid, 0);

        // R1 R2 reset config: 1 bit, divisor 2, no capture
        go(32'h8000_0000, 1'b0, 32'h0, 1'b0);
        check(m_busy == 4, "R1", "reset-config transfer length", m_busy, 4);
        check(m_edges == 2, "R6", "edges for 1 bit", m_edges, 2);

        // R10 R2 R3 R6 R7: 8 bits, divisor 4, mode 0, cs0 active low
        reg_write(1'b1, mk_cfg(0, 1, 1, 0, 0, 0, 0, 0, 8, 4, 8'h01));
        check({cs_oe, sclk_oe, mosi_oe} == 3'b111, "R10", "unpark takes effect", {cs_oe, sclk_oe, mosi_oe}, 3'b111);
        d = 32'hA5C3_1234;
        go(d, 1'b1, model_rx(d, 8, 0, 0), 1'b0);
        check(m_busy == 36, "R2", "busy cycles n=8 div=4", m_busy, 36);
        check(m_edges == 16, "R6", "clock edges n=8", m_edges, 16);
        check(m_act == 16, "R3", "active-level cycles div=4", m_act, 16);
        check(m_cs == 8'hFE, "R7", "cs during transfer", m_cs, 8'hFE);
        check(cs_o == 8'hFF, "R7", "cs released after end", cs_o, 8'hFF);

        // R5 inverted receive
        inv_rx = 1'b1;
        d = 32'h3C00_5A5A;
        go(d, 1'b1, model_rx(d, 8, 0, 1), 1'b0);
        inv_rx = 1'b0;

        // R4 R3 R6 R7: LSB first, idle high, phase 1, 12 bits, divisor 3, cs active high
        reg_write(1'b1, mk_cfg(0, 1, 1, 1, 1, 1, 1, 0, 12, 3, 8'h82));
        check(sclk_o == 1'b1, "R6", "idle level high before transfer", sclk_o, 1);
        check(cs_o == 8'h00, "R7", "active-high cs idle", cs_o, 8'h00);
        d = 32'h1357_9ABC;
        go(d, 1'b1, model_rx(d, 12, 1, 0), 1'b1);
        check(m_busy == 39, "R2", "busy cycles n=12 div=3", m_busy, 39);
        check(m_act == 24, "R3", "long active half phase 1 div=3", m_act, 24);
        check(m_edges == 24, "R6", "clock edges n=12", m_edges, 24);
        check(m_cs == 8'h82, "R7", "active-high cs pattern", m_cs, 8'h82);
        check(sclk_o == 1'b1, "R6", "idle high after transfer", sclk_o, 1);

        // R3 odd divisor, phase 0
        reg_write(1'b1, mk_cfg(0, 1, 1, 0, 0, 0, 0, 0, 5, 5, 8'h01));
        d = 32'hF0F0_0F0F;
        go(d, 1'b1, model_rx(d, 5, 0, 0), 1'b0);
        check(m_busy == 30, "R2", "busy cycles n=5 div=5", m_busy, 30);
        check(m_act == 10, "R3", "short active half phase 0 div=5", m_act, 10);

        // R4 full 32-bit word, fastest divisor
        reg_write(1'b1, mk_cfg(0, 1, 1, 0, 0, 0, 0, 0, 32, 2, 8'h01));
        d = 32'hDEAD_BEEF;
        go(d, 1'b1, d, 1'b0);
        check(m_busy == 66, "R2", "busy cycles n=32 div=2", m_busy, 66);

        // R9 writes during busy are dropped
        reg_write(1'b1, mk_cfg(0, 1, 1, 0, 0, 0, 0, 0, 16, 8, 8'h01));
        d = 32'h0F1E_2D3C;
        exp_q.push_back(model_rx(d, 16, 0, 0));
        reg_write(1'b0, d);
        repeat (2) @(negedge clk);
        reg_write(1'b1, mk_cfg(1, 1, 0, 0, 0, 0, 0, 0, 1, 2, 8'h00));
        check(cs_oe == 1'b1 && sclk_oe == 1'b1, "R9", "park write while busy ignored", {cs_oe, sclk_oe}, 2'b11);
        reg_write(1'b0, 32'h0);
        measure(1'b0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9", "data write while busy ignored", busy, 0);
        check(cs_oe == 1'b1, "R9", "still unparked after transfer", cs_oe, 1);

        // R7 R10 multi-transfer transaction
        reg_write(1'b1, mk_cfg(0, 0, 1, 0, 0, 0, 0, 0, 8, 2, 8'h04));
        d = 32'h1100_0000;
        go(d, 1'b1, model_rx(d, 8, 0, 0), 1'b0);
        check(cs_o == 8'hFB, "R7", "cs held between transfers", cs_o, 8'hFB);
        reg_write(1'b1, mk_cfg(0, 1, 1, 0, 0, 0, 0, 0, 8, 2, 8'h08));
        check(cs_o == 8'hFB, "R10", "new pattern deferred", cs_o, 8'hFB);
        d = 32'h2200_0000;
        go(d, 1'b1, model_rx(d, 8, 0, 0), 1'b0);
        check(m_cs == 8'hF7, "R10", "new pattern at next transfer", m_cs, 8'hF7);
        check(cs_o == 8'hFF, "R7", "cs released after end transfer", cs_o, 8'hFF);

        // R12 three-wire capture
        reg_write(1'b1, mk_cfg(0, 1, 1, 0, 0, 0, 0, 1, 8, 4, 8'h01));
        hd_level = 1'b1; inv_rx = 1'b1;
        d = 32'h0000_00FF;
        go(d, 1'b1, model_rx(d, 8, 0, 2), 1'b0);
        check(m_mosi_oe == 1'b0, "R12", "data out released during capture", m_mosi_oe, 0);
        check(mosi_oe == 1'b1, "R12", "data out enabled after", mosi_oe, 1);
        hd_level = 1'b0; inv_rx = 1'b0;

        // R11 no strobe without capture
        reg_write(1'b1, mk_cfg(0, 1, 0, 0, 0, 0, 0, 0, 8, 2, 8'h01));
        s0 = strobes;
        go(32'h5500_0000, 1'b0, 32'h0, 1'b0);
        repeat (5) @(negedge clk);
        check(strobes == s0, "R11", "no strobe when capture clear", strobes, s0);

        // R10 park immediate
        reg_write(1'b1, mk_cfg(1, 1, 0, 0, 0, 0, 0, 0, 8, 2, 8'h01));
        check({cs_oe, sclk_oe, mosi_oe} == 3'b000, "R10", "park immediate", {cs_oe, sclk_oe, mosi_oe}, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R11", "all expected strobes seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule